// File: doc/BRIEF.md
# Serial DAC Input Register Front End

This block is the digital front end of a 12-bit voltage-output converter. A host sends 16-bit words over three wires: a serial clock, a data line and an active-low frame select. While the frame is open, each falling serial-clock edge takes one data bit, MSB first. The word only counts once exactly sixteen bits have arrived. Of those bits, only the last twelve are kept, and they form the converter code.

A separate active-low load strobe moves a completed word into the holding latch that drives the converter. A falling strobe after a complete word updates the latch (manual mode). If the strobe is simply held low, the latch updates by itself when the sixteenth bit arrives (automatic mode). The latch code is two's complement: 0x800 is the most negative level, 0x7FF the most positive, and 0x000 is bipolar zero. The block presents the latch both as a raw code and as a sign-extended value.

All serial inputs are brought into a fast system clock through two-flop synchronizers, and their edges are detected in that domain. The system clock must be fast enough to sample every serial-clock phase at least twice. At the fastest serial rate, 5 MHz (200 ns period), each phase is at least 80 ns long.

Top module: `sdac_frontend`

## Requirements
- R1: While reset is asserted, and after it, the latch code is 0x000 and the signed value is 0.
- R2: A bit is taken only on a falling serial-clock edge. Bits are taken MSB first, and the latch receives the last twelve bits of the 16-bit word, so the upper four bits have no effect on it.
- R3: With the load strobe high, a completed word leaves the latch unchanged. A later falling edge of the strobe copies the word into the latch.
- R4: With the load strobe held low, the latch updates on its own after the sixteenth bit of each frame, with no strobe edge.
- R5: If the frame closes before sixteen bits, the partial word is discarded. A later strobe edge does not load it, no automatic load occurs, and the next frame counts from bit one.
- R6: Falling serial-clock edges beyond the sixteenth within one frame are ignored. The latch receives the low twelve bits of the first sixteen.
- R7: The signed output equals the latch code sign-extended to 16 bits. Code 0x800 gives -2048 and 0x7FF gives +2047.
- R8: Falling serial-clock edges while the frame is closed do not alter a completed word that is waiting for its load strobe.
- R9: A strobe falling edge in the same system cycle as the sixteenth bit's clock edge loads the new word.
- R10: The latch changes only on a manual or automatic load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that oversamples the serial inputs |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock; data is taken on its falling edge |
| sdata_i | input | 1 | Serial data, MSB first |
| frame_ni | input | 1 | Active-low frame select |
| load_ni | input | 1 | Active-low load strobe; hold low for automatic update |
| code_o | output | 12 | Latch contents, two's complement |
| level_o | output | 16 | Latch contents sign-extended |

## Verification
Two events can coincide: the strobe's falling edge and the sixteenth bit. A strobe edge alone is ignored while no complete word is present, yet the same low strobe must still trigger the automatic load of the word that has just completed. The bench provokes this by changing the strobe and the serial clock at the same system-clock edge, so both pass through their synchronizers together. It then expects the latch to hold the new word rather than the previous one.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int unsigned FRAME_LEN_D = 16;
  localparam int unsigned DAC_W_D     = 12;
  localparam int unsigned OUT_W_D     = 16;
  localparam int unsigned SYNC_W      = 4;
  // synchronizer lane order
  localparam int unsigned LN_SCLK  = 0;
  localparam int unsigned LN_SDATA = 1;
  localparam int unsigned LN_FRAME = 2;
  localparam int unsigned LN_LOAD  = 3;
  // idle values: clock high, data low, frame and load released
  localparam logic [SYNC_W-1:0] SYNC_IDLE = 4'b1101;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int unsigned W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_lane
    logic meta_q, sync_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= RST_VAL[i];
        sync_q <= RST_VAL[i];
      end else begin
        meta_q <= d_i[i];
        sync_q <= meta_q;
      end
    end
    assign q_o[i] = sync_q;
  end
endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter #(
  parameter int unsigned FRAME_LEN = 16,
  parameter int unsigned DAC_W     = 12,
  parameter int unsigned CNT_W     = $clog2(FRAME_LEN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sclk_s_i,
  input  logic             sdata_s_i,
  input  logic             frame_n_s_i,
  output logic [DAC_W-1:0] word_o,
  output logic             full_o,
  output logic             done_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] CAP  = CNT_W'(FRAME_LEN);

  logic             sclk_q;
  logic             sclk_fall;
  logic             shift_en;
  logic             last_bit;
  logic [CNT_W-1:0] cnt_q;
  logic [DAC_W-1:0] word_q;
  logic             full_q, done_q;

  assign sclk_fall = sclk_q & ~sclk_s_i;
  assign shift_en  = sclk_fall & ~frame_n_s_i & (cnt_q < CAP);
  assign last_bit  = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b1;
    else         sclk_q <= sclk_s_i;
  end

  // saturating count; closing the frame restarts it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (frame_n_s_i) cnt_q <= '0;
    else if (shift_en)    cnt_q <= cnt_q + 1'b1;
  end

  // only the trailing DAC_W bits survive; leading bits fall off the top
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       word_q <= '0;
    else if (shift_en) word_q <= {word_q[DAC_W-2:0], sdata_s_i};
  end

  // first bit of any frame invalidates the held word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= shift_en & last_bit;
      if (shift_en) full_q <= last_bit;
    end
  end

  assign word_o = word_q;
  assign full_o = full_q;
  assign done_o = done_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/sdac_latch.sv
module sdac_latch #(
  parameter int unsigned DAC_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_n_s_i,
  input  logic             full_i,
  input  logic             done_i,
  input  logic [DAC_W-1:0] word_i,
  output logic             we_o,
  output logic [DAC_W-1:0] code_o
);
  logic             load_q;
  logic             load_fall;
  logic             manual_ld, auto_ld;
  logic [DAC_W-1:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) load_q <= 1'b1;
    else         load_q <= load_n_s_i;
  end

  assign load_fall = load_q & ~load_n_s_i;
  assign manual_ld = load_fall & full_i;
  // strobe low when the word completes covers both tied-low and coincident edges
  assign auto_ld   = done_i & ~load_n_s_i;
  assign we_o      = manual_ld | auto_ld;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   code_q <= '0;
    else if (we_o) code_q <= word_i;
  end

  assign code_o = code_q;
endmodule

// File: rtl/sdac_frontend.sv
module sdac_frontend
  import sdac_pkg::*;
#(
  parameter int unsigned FRAME_LEN = FRAME_LEN_D,
  parameter int unsigned DAC_W     = DAC_W_D,
  parameter int unsigned OUT_W     = OUT_W_D
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sclk_i,
  input  logic             sdata_i,
  input  logic             frame_ni,
  input  logic             load_ni,
  output logic [DAC_W-1:0] code_o,
  output logic [OUT_W-1:0] level_o
);
  localparam int unsigned CNT_W = $clog2(FRAME_LEN + 1);
  localparam int unsigned EXT_W = OUT_W - DAC_W;

  logic [SYNC_W-1:0] raw, syn;
  logic              frame_n_s;
  logic [DAC_W-1:0]  shreg_q;
  logic              full, done, latch_we;
  logic [CNT_W-1:0]  bit_cnt;

  assign raw[LN_SCLK]  = sclk_i;
  assign raw[LN_SDATA] = sdata_i;
  assign raw[LN_FRAME] = frame_ni;
  assign raw[LN_LOAD]  = load_ni;

  sdac_sync #(.W(SYNC_W), .RST_VAL(SYNC_IDLE)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw),
    .q_o    (syn)
  );

  assign frame_n_s = syn[LN_FRAME];

  sdac_shifter #(.FRAME_LEN(FRAME_LEN), .DAC_W(DAC_W), .CNT_W(CNT_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sclk_s_i    (syn[LN_SCLK]),
    .sdata_s_i   (syn[LN_SDATA]),
    .frame_n_s_i (frame_n_s),
    .word_o      (shreg_q),
    .full_o      (full),
    .done_o      (done),
    .cnt_o       (bit_cnt)
  );

  sdac_latch #(.DAC_W(DAC_W)) u_latch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_n_s_i (syn[LN_LOAD]),
    .full_i     (full),
    .done_i     (done),
    .word_i     (shreg_q),
    .we_o       (latch_we),
    .code_o     (code_o)
  );

  if (EXT_W > 0) begin : g_ext
    assign level_o = {{EXT_W{code_o[DAC_W-1]}}, code_o};
  end else begin : g_noext
    assign level_o = code_o[OUT_W-1:0];
  end
endmodule

// File: rtl/sdac_frontend_chk.sv
module sdac_frontend_chk #(
  parameter int unsigned FRAME_LEN = 16,
  parameter int unsigned DAC_W     = 12,
  parameter int unsigned OUT_W     = 16,
  parameter int unsigned CNT_W     = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [DAC_W-1:0] code_o,
  input logic [OUT_W-1:0] level_o,
  input logic             latch_we,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             frame_n_s,
  input logic [DAC_W-1:0] shreg_q
);
  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) rst_zero_chk: assert (code_o == '0);
  end

  // R7
  level_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $signed(level_o) == $signed(code_o));

  // R10
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_we |=> $stable(code_o));

  // R3
  latch_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_we |=> code_o == $past(shreg_q));

  // R6
  cnt_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt <= CNT_W'(FRAME_LEN));

  // R5
  frame_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_n_s |=> bit_cnt == '0);
endmodule

bind sdac_frontend sdac_frontend_chk #(
  .FRAME_LEN (FRAME_LEN),
  .DAC_W     (DAC_W),
  .OUT_W     (OUT_W),
  .CNT_W     (CNT_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .code_o    (code_o),
  .level_o   (level_o),
  .latch_we  (latch_we),
  .bit_cnt   (bit_cnt),
  .frame_n_s (frame_n_s),
  .shreg_q   (shreg_q)
);

// File: tb/tb_sdac_frontend.sv
module tb_sdac_frontend;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;   // system clocks per serial phase

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b1, sdata = 1'b0, frame_n = 1'b1, load_n = 1'b1;
  logic [11:0] code_o;
  logic [15:0] level_o;
  int          checks = 0, fails = 0;
  logic [11:0] model = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdac_frontend dut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdata_i(sdata),
    .frame_ni(frame_n), .load_ni(load_n), .code_o(code_o), .level_o(level_o)
  );

  function automatic int sext12(logic [11:0] c);
    return c[11] ? int'(c) - 4096 : int'(c);
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [11:0] exp);
    tick(8);
    checks++;
    if (code_o !== exp || int'($signed(level_o)) != sext12(exp)) begin
      fails++;
      $display("FAIL %s: code=%h level=%0d expected code=%h level=%0d",
               req, code_o, $signed(level_o), exp, sext12(exp));
    end
  endtask

  task automatic shift_bit(logic b);
    sdata = b;
    tick(HALF);
    sclk = 1'b0;
    tick(HALF);
    sclk = 1'b1;
  endtask

  task automatic send(logic [31:0] w, int n);
    frame_n = 1'b0;
    tick(HALF);
    for (int i = n - 1; i >= 0; i--) shift_bit(w[i]);
    tick(HALF);
    frame_n = 1'b1;
    tick(HALF);
  endtask

  task automatic pulse_load();
    load_n = 1'b0;
    tick(HALF);
    load_n = 1'b1;
    tick(HALF);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    int unsigned seed_v;
    logic [15:0] w;
    logic        auto_m;
    seed_v = $urandom(32'h5eed_0233);
    tick(3);
    check("R1 in reset", 12'h000);
    rst_n = 1'b1;
    check("R1 after reset", 12'h000);

    // R3 / R10: no strobe, no change; R2 upper nibble dropped
    send(32'h0000_F123, 16);
    check("R10 no strobe", model);
    pulse_load();
    model = 12'h123;
    check("R3 manual load R2", model);

    // R7 extremes
    send(32'h0000_0800, 16); pulse_load(); model = 12'h800;
    check("R7 most negative", model);
    send(32'h0000_C7FF, 16); pulse_load(); model = 12'h7FF;
    check("R7 most positive", model);

    // R8: edges with frame closed do not disturb held word
    send(32'h0000_0A5C, 16);
    for (int i = 0; i < 8; i++) shift_bit(1'b1);
    pulse_load(); model = 12'hA5C;
    check("R8 closed-frame edges", model);

    // R5: partial word, manual then automatic
    send(32'h0000_03FF, 10);
    pulse_load();
    check("R5 partial manual", model);
    load_n = 1'b0;
    tick(HALF);
    send(32'h0000_0FFF, 12);
    check("R5 partial auto", model);
    send(32'h0000_0321, 16); model = 12'h321;
    check("R4 auto load R5 fresh count", model);
    send(32'h0000_9FED, 16); model = 12'hFED;
    check("R4 auto second word", model);
    load_n = 1'b1;
    tick(HALF);

    // R6: 20 edges in one frame, first 16 count
    send(32'h000A_BCDE, 20);
    pulse_load(); model = 12'hBCD;
    check("R6 extra edges", model);

    // R9: strobe falls with the 16th bit
    frame_n = 1'b0;
    tick(HALF);
    for (int i = 15; i >= 1; i--) shift_bit(1'(16'h0456 >> i));
    sdata = 1'b0;
    tick(HALF);
    sclk = 1'b0; load_n = 1'b0;
    tick(HALF);
    sclk = 1'b1;
    tick(HALF);
    frame_n = 1'b1;
    model = 12'h456;
    check("R9 coincident strobe", model);
    load_n = 1'b1;
    tick(HALF);

    // random mix of both modes
    for (int k = 0; k < 24; k++) begin
      w      = 16'($urandom());
      auto_m = 1'($urandom() & 1);
      if (auto_m) begin
        load_n = 1'b0;
        tick(HALF);
      end
      send({16'h0, w}, 16);
      if (!auto_m) pulse_load();
      model = w[11:0];
      check(auto_m ? "R4 random" : "R3 random R2", model);
      load_n = 1'b1;
      tick(HALF);
    end

    summary();
    $finish;
  end
endmodule